// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block forms the word a host sees on the 16-bit data bus when it reads the memory while an embedded program or erase is in progress, or after one has ended in a way that still needs acknowledging. A rising edge on `busy` starts an operation. At that edge the block records the operation kind and the polling reference bit of the word being written. From then on it reports progress in four bit positions and drives every other bit to 0.

The host can poll for completion in either of two ways. It can watch bit 7, whose polarity depends on a one-bit configuration input. It can also watch bit 6, which flips on every read strobe while work is pending. Failures are latched during the operation. A failure caused by the pulse limit or a protected target appears on bit 5, and a supply level too low to program appears on bit 3. Any failure keeps the device in status mode until an exit command arrives. With the configuration set to hold, a successful completion also waits for the exit command. The array model and the command decoder are outside this block.

Top module: `status_word_gen`

## Requirements
- R1: While reset is asserted and immediately after it, `status_hold` is 0 and `status_word` is 0.
- R2: With `cfg_hold`=0, bit 7 is the inverse of bit 7 of `last_data` (captured when `busy` rises) during a program (`op_kind`=2'b00), both while running and after a failure. For either erase kind (2'b01 sector, 2'b10 chip) it is 0.
- R3: With `cfg_hold`=1, bit 7 is 0 while the operation runs and 1 once it has ended, whether it succeeded or failed, until the block returns to read mode.
- R4: Bit 6 inverts after each cycle with `rd_strobe` high while running or failed, and holds its value otherwise. It is 0 in the cycle after `busy` rises, even if a read strobe occurs in the rising cycle.
- R5: Bit 5 is 0 while running. After the operation ends, bit 5 is 1 if `fail_flag` was high in any cycle from the start cycle to the end cycle.
- R6: Bit 3 is 1 while running or failed once `vpp_low` has been seen high in any cycle of the operation. It is 0 after a successful end.
- R7: If any failure was seen, the end of the operation (`busy` low) leaves `status_hold` at 1 until a cycle with `exit_cmd` high, whatever `cfg_hold` is. `exit_cmd` has no effect while running.
- R8: On a successful end, `status_hold` drops in the next cycle if `cfg_hold`=0. If `cfg_hold`=1 it stays at 1 with bit 7 set until `exit_cmd`.
- R9: Bits 15:8, 4, 2, 1 and 0 are always 0, and the whole word is 0 whenever `status_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | High while the embedded operation is running; the rising edge starts one |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase |
| last_data | input | 16 | Last data word loaded for programming |
| cfg_hold | input | 1 | Configuration: 0 returns to read mode after success, 1 holds until exit |
| vpp_low | input | 1 | Programming supply too low |
| fail_flag | input | 1 | Pulse-limit, bad-bit or protected-target failure |
| rd_strobe | input | 1 | Host read of the status word this cycle |
| exit_cmd | input | 1 | Exit command from the decoder |
| status_word | output | 16 | Status word for the data bus |
| status_hold | output | 1 | Device must stay in status mode |

## Verification
Two events can fall in the same cycle. The first pair is a read strobe in the cycle where `busy` rises. The bench drives reads on every cycle of an operation, including its first one, and also restarts an operation from a failed state whose toggle bit is 1. The reference model then expects bit 6 to be 0 in the next cycle, so the clear must win over the advance. The second pair is an exit command during a running erase that later fails. The model expects the command to be dropped and the failure hold to remain after `busy` falls.

// File: rtl/stw_pkg.sv
// Package: shared encodings for the program/erase status word generator.
// Assumes a data bus of at least 8 bits; bit positions are fixed by the
// polling protocol the host software follows.
package stw_pkg;
    localparam int POS_POLL = 7;
    localparam int POS_TGL  = 6;
    localparam int POS_FAIL = 5;
    localparam int POS_VPP  = 3;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10
    } op_e;

    typedef enum logic [1:0] {
        PH_READ  = 2'b00,
        PH_RUN   = 2'b01,
        PH_DONE  = 2'b10,
        PH_FAULT = 2'b11
    } phase_e;
endpackage

// File: rtl/stw_phase_ctrl.sv
// Module: stw_phase_ctrl
// Tracks the phase of an embedded operation (read, running, done-waiting,
// fault), latches failure flags seen while running and the operation
// context captured at start. Assumes busy is a level from the sequencer.
module stw_phase_ctrl
    import stw_pkg::*;
#(
    parameter int OP_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic [OP_W-1:0] op_kind,
    input  logic            poll_src,
    input  logic            cfg_hold,
    input  logic            vpp_low,
    input  logic            fail_flag,
    input  logic            exit_cmd,
    output phase_e          phase,
    output logic            start,
    output logic            vpp_err,
    output logic            lim_err,
    output logic            is_prog,
    output logic            poll_ref
);
    logic   busy_q;
    logic   vpp_nx;
    logic   lim_nx;
    phase_e phase_nx;

    // Start is the rising edge of busy relative to the registered copy.
    assign start = busy & ~busy_q;

    // Error flags including this cycle's inputs, used at the end decision.
    assign vpp_nx = vpp_err | vpp_low;
    assign lim_nx = lim_err | fail_flag;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        if (start) begin
            phase_nx = PH_RUN;
        end else begin
            unique case (phase)
                PH_RUN:   if (!busy) phase_nx = (vpp_nx || lim_nx) ? PH_FAULT
                                               : (cfg_hold ? PH_DONE : PH_READ);
                PH_DONE:  if (exit_cmd) phase_nx = PH_READ;
                PH_FAULT: if (exit_cmd) phase_nx = PH_READ;
                default:  phase_nx = phase;
            endcase
        end
    end

    // Phase and busy edge register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_READ;
            busy_q <= 1'b0;
        end else begin
            phase  <= phase_nx;
            busy_q <= busy;
        end
    end

    // Failure latches: reloaded at start, accumulated while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpp_err <= 1'b0;
            lim_err <= 1'b0;
        end else if (start) begin
            vpp_err <= vpp_low;
            lim_err <= fail_flag;
        end else if (phase == PH_RUN) begin
            vpp_err <= vpp_nx;
            lim_err <= lim_nx;
        end
    end

    // Operation context captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_prog  <= 1'b0;
            poll_ref <= 1'b0;
        end else if (start) begin
            is_prog  <= (op_kind == OP_W'(OP_PROG));
            poll_ref <= poll_src;
        end
    end
endmodule

// File: rtl/stw_toggle.sv
// Module: stw_toggle
// Toggle bit source. Cleared on start (start wins over a same-cycle read),
// inverted on each read strobe while advancing is allowed.
module stw_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_strobe,
    input  logic adv_ok,
    output logic tog
);
    // Toggle register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (start) begin
            tog <= 1'b0;
        end else if (rd_strobe && adv_ok) begin
            tog <= ~tog;
        end
    end
endmodule

// File: rtl/stw_word_fmt.sv
// Module: stw_word_fmt
// Combinational formatter of the status word from the phase and latched
// flags. Bits without a status meaning are driven to 0.
module stw_word_fmt
    import stw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  phase_e            phase,
    input  logic              cfg_hold,
    input  logic              is_prog,
    input  logic              poll_ref,
    input  logic              tog,
    input  logic              vpp_err,
    input  logic              lim_err,
    output logic [DATA_W-1:0] word
);
    logic poll_auto;
    logic poll_bit;
    logic active;

    // Auto-return mode polling value: inverted reference for program only.
    assign poll_auto = is_prog & ~poll_ref;
    assign active    = (phase != PH_READ);

    // Bit 7 per phase and configuration.
    always_comb begin
        unique case (phase)
            PH_RUN:   poll_bit = cfg_hold ? 1'b0 : poll_auto;
            PH_FAULT: poll_bit = cfg_hold ? 1'b1 : poll_auto;
            PH_DONE:  poll_bit = 1'b1;
            default:  poll_bit = 1'b0;
        endcase
    end

    // Assemble the word bit by bit.
    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            unique case (b)
                POS_POLL: word[b] = poll_bit;
                POS_TGL:  word[b] = active & tog;
                POS_FAIL: word[b] = (phase == PH_FAULT) & lim_err;
                POS_VPP:  word[b] = ((phase == PH_FAULT) || (phase == PH_RUN)) & vpp_err;
                default:  word[b] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/status_word_gen.sv
// Module: status_word_gen
// Top of the program/erase status word generator. Composes the phase
// controller, the toggle source and the word formatter. Assumes DATA_W >= 8.
module status_word_gen
    import stw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [OP_W-1:0]   op_kind,
    input  logic [DATA_W-1:0] last_data,
    input  logic              cfg_hold,
    input  logic              vpp_low,
    input  logic              fail_flag,
    input  logic              rd_strobe,
    input  logic              exit_cmd,
    output logic [DATA_W-1:0] status_word,
    output logic              status_hold
);
    localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POS_POLL;

    phase_e phase;
    logic   start;
    logic   vpp_err;
    logic   lim_err;
    logic   is_prog;
    logic   poll_ref;
    logic   tog;
    logic   adv_ok;
    logic   unused_data_bits;

    // Only the polling bit of the loaded word matters here.
    assign unused_data_bits = ^(last_data & ~POLL_MASK);
    assign adv_ok      = (phase == PH_RUN) || (phase == PH_FAULT);
    assign status_hold = (phase != PH_READ);

    stw_phase_ctrl #(.OP_W(OP_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .op_kind   (op_kind),
        .poll_src  (last_data[POS_POLL]),
        .cfg_hold  (cfg_hold),
        .vpp_low   (vpp_low),
        .fail_flag (fail_flag),
        .exit_cmd  (exit_cmd),
        .phase     (phase),
        .start     (start),
        .vpp_err   (vpp_err),
        .lim_err   (lim_err),
        .is_prog   (is_prog),
        .poll_ref  (poll_ref)
    );

    stw_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_strobe (rd_strobe),
        .adv_ok    (adv_ok),
        .tog       (tog)
    );

    stw_word_fmt #(.DATA_W(DATA_W)) u_fmt (
        .phase    (phase),
        .cfg_hold (cfg_hold),
        .is_prog  (is_prog),
        .poll_ref (poll_ref),
        .tog      (tog),
        .vpp_err  (vpp_err),
        .lim_err  (lim_err),
        .word     (status_word)
    );
endmodule

// File: rtl/stw_checker.sv
// Module: stw_checker
// Port-level temporal checks on status_word_gen, attached by bind.
module stw_checker
    import stw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cfg_hold,
    input logic              rd_strobe,
    input logic              exit_cmd,
    input logic [DATA_W-1:0] status_word,
    input logic              status_hold
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << POS_POLL) | (DATA_W'(1) << POS_TGL) |
        (DATA_W'(1) << POS_FAIL) | (DATA_W'(1) << POS_VPP);

    logic busy_d;
    logic rose_d;

    // Remember whether an operation started at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d <= 1'b0;
            rose_d <= 1'b0;
        end else begin
            busy_d <= busy;
            rose_d <= busy & ~busy_d;
        end
    end

    assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~LIVE_MASK) == '0);

    assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_hold |-> status_word == '0);

    assert_start_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (status_hold && !status_word[POS_TGL]));

    assert_toggle_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_hold && $past(status_hold) && !$past(rd_strobe) && !rose_d)
        |-> $stable(status_word[POS_TGL]));

    assert_run_nofail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !status_word[POS_FAIL]);

    assert_run_poll_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hold && busy && $past(busy)) |-> !status_word[POS_POLL]);

    assert_exit_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_cmd && !busy && !$past(busy)) |=> !status_hold);
endmodule

bind status_word_gen stw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .cfg_hold    (cfg_hold),
    .rd_strobe   (rd_strobe),
    .exit_cmd    (exit_cmd),
    .status_word (status_word),
    .status_hold (status_hold)
);

// File: tb/status_word_gen_bench.sv
module status_word_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [DW-1:0] last_data = '0;
    logic          cfg_hold = 1'b0;
    logic          vpp_low = 1'b0;
    logic          fail_flag = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          exit_cmd = 1'b0;
    logic [DW-1:0] status_word;
    logic          status_hold;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Behavioural model: 0 read, 1 running, 2 done-waiting, 3 fault.
    int m_ph = 0;
    bit m_tog = 0, m_prog = 0, m_d7 = 0, m_ev = 0, m_el = 0, m_bq = 0;

    status_word_gen u_status_word_gen (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_kind(op_kind),
        .last_data(last_data), .cfg_hold(cfg_hold), .vpp_low(vpp_low),
        .fail_flag(fail_flag), .rd_strobe(rd_strobe), .exit_cmd(exit_cmd),
        .status_word(status_word), .status_hold(status_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit st;
        st = busy && !m_bq;
        if (st) begin
            m_ph = 1; m_tog = 0; m_prog = (op_kind == 2'b00);
            m_d7 = last_data[7]; m_ev = vpp_low; m_el = fail_flag;
        end else if (m_ph == 1) begin
            if (rd_strobe) m_tog = !m_tog;
            m_ev = m_ev | vpp_low;
            m_el = m_el | fail_flag;
            if (!busy) m_ph = (m_ev || m_el) ? 3 : (cfg_hold ? 2 : 0);
        end else if (m_ph == 3) begin
            if (rd_strobe) m_tog = !m_tog;
            if (exit_cmd) m_ph = 0;
        end else if (m_ph == 2) begin
            if (exit_cmd) m_ph = 0;
        end
        m_bq = busy;
    endtask

    function automatic logic [DW-1:0] exp_word();
        logic [DW-1:0] w = '0;
        case (m_ph)
            1: begin w[7] = cfg_hold ? 1'b0 : (m_prog && !m_d7); w[6] = m_tog; w[3] = m_ev; end
            2: begin w[7] = 1'b1; w[6] = m_tog; end
            3: begin w[7] = cfg_hold ? 1'b1 : (m_prog && !m_d7); w[6] = m_tog;
                     w[5] = m_el; w[3] = m_ev; end
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic compare_all();
        logic [DW-1:0] e;
        logic [DW-1:0] spare;
        e = exp_word();
        spare = 16'hFF17;
        chk(status_hold === (m_ph != 0), "R7", status_hold, m_ph != 0, "hold");
        chk(status_word[7] === e[7], cfg_hold ? "R3" : "R2", status_word[7], e[7], "bit7");
        chk(status_word[6] === e[6], "R4", status_word[6], e[6], "bit6");
        chk(status_word[5] === e[5], "R5", status_word[5], e[5], "bit5");
        chk(status_word[3] === e[3], "R6", status_word[3], e[3], "bit3");
        chk((status_word & spare) === (e & spare), "R9", status_word, e, "spare bits");
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        else begin m_ph = 0; m_tog = 0; m_ev = 0; m_el = 0; m_bq = 0; end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_op(input logic [1:0] op, input logic [DW-1:0] d, input int len,
                         input int fail_at, input int vpp_at, input bit rd_all,
                         input bit ex_during);
        op_kind = op; last_data = d; busy = 1'b1;
        for (int i = 0; i < len; i++) begin
            rd_strobe = rd_all; fail_flag = (i == fail_at); vpp_low = (i == vpp_at);
            exit_cmd = ex_during && (i > 0);
            tick();
        end
        busy = 1'b0; rd_strobe = 1'b0; fail_flag = 1'b0; vpp_low = 1'b0; exit_cmd = 1'b0;
        tick();
    endtask

    task automatic idle(input int n, input bit rd, input bit ex);
        for (int i = 0; i < n; i++) begin
            rd_strobe = rd; exit_cmd = ex;
            tick();
        end
        rd_strobe = 1'b0; exit_cmd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        chk(status_hold === 1'b0 && status_word === '0, "R1", status_word, 0, "reset");
        rst_n = 1'b1;
        tick();
        chk(status_hold === 1'b0 && status_word === '0, "R1", status_word, 0, "after reset");

        // Auto-return mode, program with bit7=1, reads every cycle.
        cfg_hold = 1'b0;
        do_op(2'b00, 16'h0080, 5, -1, -1, 1'b1, 1'b0);
        chk(status_hold === 1'b0, "R8", status_hold, 0, "auto return after success");
        // Program with bit7=0, no reads: bit 7 shows 1, toggle frozen.
        do_op(2'b00, 16'h0011, 4, -1, -1, 1'b0, 1'b0);
        // Sector erase: bit 7 reads 0.
        do_op(2'b01, 16'hFFFF, 3, -1, -1, 1'b1, 1'b0);

        // Hold mode success.
        cfg_hold = 1'b1;
        do_op(2'b00, 16'h00FF, 4, -1, -1, 1'b1, 1'b0);
        chk(status_hold === 1'b1, "R8", status_hold, 1, "held after success");
        chk(status_word[7] === 1'b1, "R3", status_word[7], 1, "done bit7");
        idle(2, 1'b1, 1'b0);
        idle(1, 1'b0, 1'b1);
        chk(status_hold === 1'b0, "R8", status_hold, 0, "exit releases");

        // Auto-return mode failure.
        cfg_hold = 1'b0;
        do_op(2'b00, 16'h0080, 5, 2, -1, 1'b1, 1'b0);
        chk(status_word[5] === 1'b1, "R5", status_word[5], 1, "fail flag");
        idle(3, 1'b1, 1'b0);
        chk(status_hold === 1'b1, "R7", status_hold, 1, "fault held");
        idle(1, 1'b0, 1'b1);
        chk(status_hold === 1'b0, "R7", status_hold, 0, "exit clears fault");

        // Hold mode, chip erase, low supply, exit written during run.
        cfg_hold = 1'b1;
        do_op(2'b10, 16'h0000, 5, -1, 1, 1'b1, 1'b1);
        chk(status_hold === 1'b1, "R7", status_hold, 1, "exit ignored while running");
        chk(status_word[3] === 1'b1, "R6", status_word[3], 1, "vpp bit");
        idle(1, 1'b1, 1'b0);
        // Restart from fault with toggle set, read in start cycle.
        cfg_hold = 1'b0;
        do_op(2'b00, 16'h0000, 3, -1, -1, 1'b1, 1'b0);
        chk(status_hold === 1'b0, "R8", status_hold, 0, "restart completes");
        idle(2, 1'b1, 1'b0);
        finish_run();
    end
endmodule